// File: doc/BRIEF.md
# Cache Miss Cause Classifier

This block sits beside a small direct-mapped cache and watches its access stream. For every access it receives the byte address and the hit or miss verdict of the monitored cache. It then decides why each miss happened. A cold miss touches a block that was never used before. A capacity miss is one that a fully associative cache of the same size would also have taken. A conflict miss is one where the block was lost only because another block landed on the same index.

To make this decision the block keeps two structures. The first is a bitmap with one bit for each memory block, which records whether that block has ever been used. The second is a shadow store that holds tags only. It is fully associative, uses LRU replacement and has as many entries as the monitored cache has lines. Both structures are updated on every access, hit or miss. The verdict comes out one cycle later as a two-bit code with a valid pulse, and each of the three miss causes has its own counter.

With the default parameters an address is 5 bits wide. Bit 0 is the byte offset, and bits 4:1 form the block number, which is used both as the bitmap index and as the shadow tag. The monitored cache has 4 lines, so the shadow store has 4 entries.

Top module: `mc_miss_classifier`

## Requirements
- R1: After reset, `cls_valid` is 0, all three counters are 0, no block is marked as used and the shadow store is empty.
- R2: An access that is presented with `acc_valid` high at a rising edge produces `cls_valid` high for exactly the next cycle. While `acc_valid` is low, `cls_valid` stays low, the counters hold, and neither the bitmap nor the shadow store changes.
- R3: An access reported as a hit (`acc_hit`=1) yields code 0 (none) and leaves every counter unchanged.
- R4: A miss to a block that has never been accessed yields code 1 (cold) and increments the cold counter. The block number is the address with its offset bits removed.
- R5: Hits also mark their block as used and refresh it in the shadow store. A later miss to a block that was only ever hit is therefore not cold.
- R6: A miss to a block that has been used before and is still held in the shadow store yields code 3 (conflict).
- R7: A miss to a block that has been used before but is no longer held in the shadow store yields code 2 (capacity).
- R8: When the shadow store is full, a new block replaces the least recently accessed entry. Any access, hit or miss, makes its block the most recent.
- R9: The counters saturate at their all-ones value and never wrap.
- R10: With the defaults, the address sequence 1,5,1,4,0,12,5,12,5,12,5 with verdicts M,M,H,H,H,M,M,M,M,M,M yields the codes 1,1,0,0,0,1,3,3,3,3,3.
- R11: Each counter grows by exactly one for each valid code of its own class (below saturation). After the R10 sequence the counters read cold=3, capacity=0, conflict=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_hit | input | 1 | Verdict of the monitored cache: 1 for hit |
| cls_valid | output | 1 | Classification valid pulse |
| cls_code | output | 2 | 0 none, 1 cold, 2 capacity, 3 conflict |
| cnt_cold | output | CNT_W | Saturating count of cold misses |
| cnt_cap | output | CNT_W | Saturating count of capacity misses |
| cnt_conf | output | CNT_W | Saturating count of conflict misses |

## Verification
The bench targets the cases where the two tracking structures must work together:
- **Hit followed by a miss.** A hit is followed by a miss to the same block. A design that skipped updates on hits would call that miss cold.
- **Working set one block larger than the store.** Five blocks are cycled through four entries. A design with the wrong replacement order, or one that treated an empty entry as valid, would report conflict where capacity is due.
- **Hit refreshes LRU order.** A hit is placed in the middle of a full store, then a new block is brought in. This checks that the hit changed which entry gets evicted; a store that only reordered on misses would evict the wrong block.
- **Idle cycles and saturation.** An address is held while `acc_valid` is low, to check that idle cycles leave no trace. A long run of capacity misses drives the counter to saturation, where a wrapping counter would show up as a small value.

// File: rtl/mc_pkg.sv
package mc_pkg;
   typedef enum logic [1:0] {
      CLS_NONE     = 2'd0,
      CLS_COLD     = 2'd1,
      CLS_CAPACITY = 2'd2,
      CLS_CONFLICT = 2'd3
   } miss_class_e;

   localparam int unsigned NUM_CLASSES = 3;
endpackage

// File: rtl/mc_ref_history.sv
// One bit per memory block: set once the block has been accessed.
module mc_ref_history #(
   parameter int unsigned BLK_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [BLK_W-1:0] blk,
   input  logic             mark_en,
   output logic             seen
);
   localparam int unsigned NBLK = 1 << BLK_W;

   logic [NBLK-1:0] used_q;

   assign seen = used_q[blk];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         used_q <= '0;
      end else if (mark_en) begin
         used_q[blk] <= 1'b1;
      end
   end
endmodule

// File: rtl/mc_shadow_lru.sv
// Tag-only fully associative store with true LRU ordering by age ranks.
// Ages always form a permutation of 0..ENTRIES-1; the oldest is the victim.
module mc_shadow_lru #(
   parameter int unsigned TAG_W   = 4,
   parameter int unsigned ENTRIES = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TAG_W-1:0] tag,
   input  logic             update_en,
   output logic             present
);
   localparam int unsigned AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
   localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(ENTRIES - 1);

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [AGE_W-1:0]   age_q [ENTRIES];
   logic [ENTRIES-1:0] match;
   logic [AGE_W-1:0]   ref_age;

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
         assign match[i] = valid_q[i] && (tag_q[i] == tag);
      end
   endgenerate

   assign present = |match;

   always_comb begin
      ref_age = present ? '0 : AGE_MAX;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) ref_age = age_q[i];
      end
   end

   generate
      for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
         logic take;
         assign take = match[i] || (!present && (age_q[i] == AGE_MAX));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               valid_q[i] <= 1'b0;
               tag_q[i]   <= '0;
               age_q[i]   <= AGE_W'(i);
            end else if (update_en) begin
               if (take) begin
                  valid_q[i] <= 1'b1;
                  tag_q[i]   <= tag;
                  age_q[i]   <= '0;
               end else if (age_q[i] < ref_age) begin
                  age_q[i]   <= age_q[i] + AGE_W'(1);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/mc_class_counter.sv
module mc_class_counter #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   output logic [CNT_W-1:0] count
);
   logic [CNT_W-1:0] cnt_q;
   logic             step;

   generate
      if (SATURATE) begin : g_sat
         assign step = inc && (cnt_q != '1);
      end else begin : g_wrap
         assign step = inc;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    cnt_q <= '0;
      else if (step) cnt_q <= cnt_q + CNT_W'(1);
   end

   assign count = cnt_q;
endmodule

// File: rtl/mc_miss_classifier.sv
module mc_miss_classifier #(
   parameter int unsigned ADDR_W   = 5,
   parameter int unsigned OFFSET_W = 1,
   parameter int unsigned INDEX_W  = 2,
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_hit,
   output logic              cls_valid,
   output logic [1:0]        cls_code,
   output logic [CNT_W-1:0]  cnt_cold,
   output logic [CNT_W-1:0]  cnt_cap,
   output logic [CNT_W-1:0]  cnt_conf
);
   import mc_pkg::*;

   localparam int unsigned BLK_W = ADDR_W - OFFSET_W;
   localparam int unsigned LINES = 1 << INDEX_W;

   generate
      if (ADDR_W <= OFFSET_W + INDEX_W) begin : g_bad_split
         $error("address must leave tag bits above index and offset");
      end
      if (BLK_W > 12) begin : g_bad_hist
         $error("block history limited to 4096 entries");
      end
      if (INDEX_W < 1 || CNT_W < 1) begin : g_bad_size
         $error("INDEX_W and CNT_W must be at least 1");
      end
   endgenerate

   logic [BLK_W-1:0] blk;
   logic             seen;
   logic             in_shadow;
   miss_class_e      next_cls;
   logic [1:0]       next_code;
   logic [CNT_W-1:0] cnt_arr [NUM_CLASSES];

   assign blk = acc_addr[ADDR_W-1:OFFSET_W];

   mc_ref_history #(.BLK_W(BLK_W)) u_hist (
      .clk     (clk),
      .rst_n   (rst_n),
      .blk     (blk),
      .mark_en (acc_valid),
      .seen    (seen)
   );

   mc_shadow_lru #(.TAG_W(BLK_W), .ENTRIES(LINES)) u_shadow (
      .clk       (clk),
      .rst_n     (rst_n),
      .tag       (blk),
      .update_en (acc_valid),
      .present   (in_shadow)
   );

   always_comb begin
      if (acc_hit)        next_cls = CLS_NONE;
      else if (!seen)     next_cls = CLS_COLD;
      else if (in_shadow) next_cls = CLS_CONFLICT;
      else                next_cls = CLS_CAPACITY;
   end

   assign next_code = next_cls;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cls_valid <= 1'b0;
         cls_code  <= 2'd0;
      end else begin
         cls_valid <= acc_valid;
         cls_code  <= acc_valid ? next_code : 2'd0;
      end
   end

   generate
      for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_cnt
         logic inc;
         assign inc = acc_valid && (next_code == 2'(k + 1));
         mc_class_counter #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc),
            .count (cnt_arr[k])
         );
      end
   endgenerate

   assign cnt_cold = cnt_arr[0];
   assign cnt_cap  = cnt_arr[1];
   assign cnt_conf = cnt_arr[2];
endmodule

// File: rtl/mc_miss_classifier_chk.sv
module mc_miss_classifier_chk #(
   parameter int unsigned CNT_W    = 8,
   parameter bit          SATURATE = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             acc_valid,
   input logic             acc_hit,
   input logic             cls_valid,
   input logic [1:0]       cls_code,
   input logic [CNT_W-1:0] cnt_cold,
   input logic [CNT_W-1:0] cnt_cap,
   input logic [CNT_W-1:0] cnt_conf
);
   localparam logic [CNT_W-1:0] CMAX = '1;

   a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> cls_valid);
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_valid |=> (!cls_valid && $stable(cnt_cold) && $stable(cnt_cap) && $stable(cnt_conf)));
   a_r3_hit_none: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_hit) |=> (cls_code == 2'd0));
   a_r4_class_needs_miss: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_code != 2'd0) |-> !$past(acc_hit));
   a_r11_cold_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_code == 2'd1 && $past(cnt_cold) != CMAX) |-> (cnt_cold == $past(cnt_cold) + CNT_W'(1)));
   a_r11_cap_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_code == 2'd2 && $past(cnt_cap) != CMAX) |-> (cnt_cap == $past(cnt_cap) + CNT_W'(1)));
   a_r11_conf_step: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_valid && cls_code == 2'd3 && $past(cnt_conf) != CMAX) |-> (cnt_conf == $past(cnt_conf) + CNT_W'(1)));

   generate
      if (SATURATE) begin : g_sat_chk
         a_r9_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt_cap == CMAX) |=> (cnt_cap == CMAX));
      end
   endgenerate
endmodule

bind mc_miss_classifier mc_miss_classifier_chk #(.CNT_W(CNT_W), .SATURATE(SATURATE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_valid (acc_valid),
   .acc_hit   (acc_hit),
   .cls_valid (cls_valid),
   .cls_code  (cls_code),
   .cnt_cold  (cnt_cold),
   .cnt_cap   (cnt_cap),
   .cnt_conf  (cnt_conf)
);

// File: tb/tb_mc_miss_classifier.sv
module tb_mc_miss_classifier;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          acc_valid = 1'b0;
   logic [4:0]    acc_addr = '0;
   logic          acc_hit = 1'b0;
   logic          cls_valid;
   logic [1:0]    cls_code;
   logic [CW-1:0] cnt_cold, cnt_cap, cnt_conf;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   mc_miss_classifier #(.CNT_W(CW)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_hit(acc_hit), .cls_valid(cls_valid), .cls_code(cls_code),
      .cnt_cold(cnt_cold), .cnt_cap(cnt_cap), .cnt_conf(cnt_conf)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; acc_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Drive at negedge, sample 5 ns after the capturing edge.
   task automatic access(input int addr, input bit hit, input int exp, input string req);
      @(negedge clk);
      acc_valid = 1'b1; acc_addr = 5'(addr); acc_hit = hit;
      @(posedge clk);
      #5;
      check(cls_valid === 1'b1, req, int'(cls_valid), 1);
      check(cls_code === 2'(exp), req, int'(cls_code), exp);
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic t_reset();   // R1
      do_reset();
      #5;
      check(cls_valid === 1'b0, "R1", int'(cls_valid), 0);
      check(cnt_cold == 0 && cnt_cap == 0 && cnt_conf == 0, "R1",
            int'(cnt_cold) + int'(cnt_cap) + int'(cnt_conf), 0);
   endtask

   task automatic t_sequence();   // R10, R11
      int addrs [11] = '{1, 5, 1, 4, 0, 12, 5, 12, 5, 12, 5};
      bit hits  [11] = '{0, 0, 1, 1, 1, 0, 0, 0, 0, 0, 0};
      int codes [11] = '{1, 1, 0, 0, 0, 1, 3, 3, 3, 3, 3};
      do_reset();
      for (int i = 0; i < 11; i++) access(addrs[i], hits[i], codes[i], "R10");
      check(cnt_cold == 3, "R11", int'(cnt_cold), 3);
      check(cnt_cap == 0, "R11", int'(cnt_cap), 0);
      check(cnt_conf == 5, "R11", int'(cnt_conf), 5);
   endtask

   task automatic t_idle();   // R2
      do_reset();
      access(6, 0, 1, "R4");
      @(negedge clk);
      acc_valid = 1'b0; acc_addr = 5'd20; acc_hit = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(posedge clk);
         #5;
         check(cls_valid === 1'b0, "R2", int'(cls_valid), 0);
         check(cnt_cold == 1, "R2", int'(cnt_cold), 1);
      end
      access(20, 0, 1, "R2");   // idle presentation left no mark: still cold
   endtask

   task automatic t_hit_marks();   // R3, R5
      do_reset();
      access(18, 1, 0, "R3");
      check(cnt_cold == 0 && cnt_conf == 0 && cnt_cap == 0, "R3",
            int'(cnt_cold) + int'(cnt_cap) + int'(cnt_conf), 0);
      access(19, 0, 3, "R5");
   endtask

   task automatic t_capacity();   // R7
      do_reset();
      for (int b = 0; b < 5; b++) access(2 * b, 0, 1, "R4");
      access(0, 0, 2, "R7");
      check(cnt_cap == 1, "R7", int'(cnt_cap), 1);
   endtask

   task automatic t_lru();   // R8
      do_reset();
      for (int b = 0; b < 4; b++) access(2 * b, 0, 1, "R4");
      access(0, 1, 0, "R8");
      access(8, 0, 1, "R8");
      access(1, 0, 3, "R8");
      access(2, 0, 2, "R8");
   endtask

   task automatic t_saturate();   // R9
      do_reset();
      for (int b = 0; b < 5; b++) access(2 * b, 0, 1, "R4");
      for (int i = 0; i < 20; i++) access(2 * (i % 5), 0, 2, "R7");
      check(cnt_cap == 15, "R9", int'(cnt_cap), 15);
      check(cnt_cold == 5, "R9", int'(cnt_cold), 5);
      check(cnt_conf == 0, "R6", int'(cnt_conf), 0);
   endtask

   initial begin
      t_reset();
      t_sequence();
      t_idle();
      t_hit_marks();
      t_capacity();
      t_lru();
      t_saturate();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule